// File: doc/BRIEF.md
# Mesh Router Output Switch Allocator

This block decides which of three competing streams may drive one output link of a node in a two-dimensional mesh or torus network. The competitors are the neighbour in the Y dimension, the neighbour in the X dimension and the node's own local terminal. Each competitor writes into its own ingress buffer. The allocator hands the output to one buffer at a time and keeps it there for the whole packet. It lets the output go only after the downstream side has accepted the word flagged as last.

Two elaboration-time choices set how the block behaves. The first is the policy. It is either a fixed ranking with Y above X above terminal, or a rotation in which the input just served drops to the bottom. The second is when a buffer may compete. Under wormhole timing it may compete once it holds any word. Under cut-through timing it must hold a whole packet. Under cut-through, a packet longer than its buffer would block forever, so a full buffer may compete anyway and then streams the packet as wormhole does.

A stall timer watches for traffic that sits in the buffers while nothing leaves. If that goes on for a set number of cycles in a row, it raises a deadlock flag. The flag stays raised until reset.

Top module: `mesh_out_alloc`

## Requirements
- R1: While reset is asserted and just after it is released, out_valid is 0, every in_ready bit is 1 and deadlock is 0.
- R2: With ROUND_ROBIN=0, competing inputs are served in a fixed order. Lane 0 (Y neighbour) goes before lane 1 (X neighbour), and lane 1 goes before lane 2 (terminal). Lane i uses bits i*DATA_W and up of in_data.
- R3: With ROUND_ROBIN=1, the lane just granted becomes the lowest-ranked for the next decision. After reset the terminal lane counts as last served, so lane 0 ranks first.
- R4: Once a lane is granted, the output carries only that lane's words until its word with in_last=1 is accepted with out_ready=1. Other lanes wait, even when the granted lane's buffer is empty in the middle of a packet.
- R5: With CUT_THROUGH=0, a lane may compete as soon as one word of its packet is buffered.
- R6: With CUT_THROUGH=1, a lane may compete only when its buffer holds a complete packet, up to and including the last word.
- R7: With CUT_THROUGH=1, a lane whose buffer is full without holding a last word may compete anyway. Its packet is then delivered complete and in order, even when it is longer than the buffer.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data and out_last hold their values.
- R9: deadlock rises after STALL_LIMIT consecutive cycles in which some buffer holds data and no output word is accepted. A shorter run of such cycles does not raise it. Any accepted output word restarts the count.
- R10: Once deadlock is 1, it stays 1 until reset.
- R11: Each lane buffer holds 2**BUF_LOG2 words. A lane's in_ready is 0 exactly while its buffer is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 3*DATA_W | Lane words: lane 0 = Y neighbour, lane 1 = X neighbour, lane 2 = terminal |
| in_last | input | 3 | Last-word flag per lane |
| in_valid | input | 3 | Word present per lane |
| in_ready | output | 3 | Lane buffer has room |
| out_data | output | DATA_W | Granted lane's head word |
| out_last | output | 1 | Head word ends its packet |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the word |
| deadlock | output | 1 | Sticky stall alarm |

## Verification
The hardest cases to reach are the ones that depend on what each buffer holds at the moment of arbitration. Examples are a partial packet on a higher lane next to a complete one on a lower lane, or a cut-through packet that overflows its buffer. The bench drives one input stream into three instances at once: fixed wormhole, rotating wormhole and fixed cut-through. A word enters only when every instance has room, so all three buffers fill identically. Loading buffers while out_ready is held low, then releasing it, fixes the competing set exactly. The same holding-back, with single-cycle releases of out_ready, sets the length of each stall run for the deadlock timer.

// File: rtl/mesh_alloc_pkg.sv
package mesh_alloc_pkg;
  localparam int NUM_SRC = 3;
  typedef logic [1:0] src_idx_t;
  localparam src_idx_t SRC_Y    = 2'd0;
  localparam src_idx_t SRC_X    = 2'd1;
  localparam src_idx_t SRC_TERM = 2'd2;
endpackage

// File: rtl/alloc_ingress_buf.sv
module alloc_ingress_buf #(
  parameter int DATA_W   = 32,
  parameter int BUF_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  output logic              wr_ready,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last,
  output logic              empty,
  output logic              full,
  output logic              has_pkt
);
  localparam int DEPTH = 1 << BUF_LOG2;
  localparam int PTR_W = BUF_LOG2 + 1;

  logic [DATA_W:0]  mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [PTR_W-1:0] pkt_q, pkt_d;
  logic             push, pop, ptr_en;

  assign empty    = (wr_ptr_q == rd_ptr_q);
  assign full     = (wr_ptr_q[BUF_LOG2] != rd_ptr_q[BUF_LOG2]) &&
                    (wr_ptr_q[BUF_LOG2-1:0] == rd_ptr_q[BUF_LOG2-1:0]);
  assign wr_ready = ~full;
  assign push     = wr_valid & ~full;
  assign pop      = rd_en & ~empty;
  assign ptr_en   = push | pop;
  assign {rd_last, rd_data} = mem[rd_ptr_q[BUF_LOG2-1:0]];
  assign has_pkt  = (pkt_q != '0);

  always_comb begin
    wr_ptr_d = wr_ptr_q + PTR_W'(push);
    rd_ptr_d = rd_ptr_q + PTR_W'(pop);
    pkt_d    = pkt_q + PTR_W'(push && wr_last) - PTR_W'(pop && rd_last);
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q[BUF_LOG2-1:0]] <= {wr_last, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      pkt_q    <= '0;
    end else if (ptr_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      pkt_q    <= pkt_d;
    end
  end
endmodule

// File: rtl/alloc_pick.sv
module alloc_pick
  import mesh_alloc_pkg::*;
#(
  parameter bit ROUND_ROBIN = 1'b0
) (
  input  logic [NUM_SRC-1:0] req,
  input  src_idx_t           last_served,
  output src_idx_t           pick,
  output logic               found
);
  src_idx_t start;

  assign start = ROUND_ROBIN ? last_served : SRC_TERM;

  always_comb begin
    pick  = SRC_Y;
    found = 1'b0;
    for (int k = 1; k <= NUM_SRC; k++) begin
      int idx;
      idx = int'(start) + k;
      if (idx >= NUM_SRC) idx = idx - NUM_SRC;
      if (!found && req[idx]) begin
        found = 1'b1;
        pick  = src_idx_t'(idx);
      end
    end
  end
endmodule

// File: rtl/alloc_stall_timer.sv
module alloc_stall_timer #(
  parameter int STALL_LIMIT = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic moved,
  output logic alarm
);
  localparam int CNT_W = $clog2(STALL_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STALL_LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             alarm_q, alarm_d;
  logic             cnt_en;

  always_comb begin
    if (moved || !pending)  cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    else                     cnt_d = cnt_q;
    cnt_en  = (cnt_d != cnt_q);
    alarm_d = alarm_q | (cnt_d == LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      alarm_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      alarm_q <= alarm_d;
    end
  end

  assign alarm = alarm_q;
endmodule

// File: rtl/mesh_out_alloc.sv
module mesh_out_alloc
  import mesh_alloc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int BUF_LOG2    = 5,
  parameter int STALL_LIMIT = 16384,
  parameter bit ROUND_ROBIN = 1'b0,
  parameter bit CUT_THROUGH = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC*DATA_W-1:0] in_data,
  input  logic [NUM_SRC-1:0]        in_last,
  input  logic [NUM_SRC-1:0]        in_valid,
  output logic [NUM_SRC-1:0]        in_ready,
  output logic [DATA_W-1:0]         out_data,
  output logic                      out_last,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic                      deadlock
);
  logic [DATA_W-1:0]  head_data [NUM_SRC];
  logic [NUM_SRC-1:0] head_last, buf_empty, buf_full, buf_pkt, rd_en, eligible;

  logic     busy_q, busy_d;
  src_idx_t gnt_q, gnt_d, last_q, last_d;
  src_idx_t pick;
  logic     found, take, xfer, gnt_en;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
    alloc_ingress_buf #(.DATA_W(DATA_W), .BUF_LOG2(BUF_LOG2)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (in_valid[i]),
      .wr_data  (in_data[i*DATA_W +: DATA_W]),
      .wr_last  (in_last[i]),
      .wr_ready (in_ready[i]),
      .rd_en    (rd_en[i]),
      .rd_data  (head_data[i]),
      .rd_last  (head_last[i]),
      .empty    (buf_empty[i]),
      .full     (buf_full[i]),
      .has_pkt  (buf_pkt[i])
    );
    if (CUT_THROUGH) begin : g_ct
      // a full buffer without a complete packet streams like wormhole
      assign eligible[i] = buf_pkt[i] | buf_full[i];
    end else begin : g_wh
      assign eligible[i] = ~buf_empty[i];
    end
    assign rd_en[i] = busy_q && (gnt_q == src_idx_t'(i)) && out_ready;
  end

  alloc_pick #(.ROUND_ROBIN(ROUND_ROBIN)) u_pick (
    .req         (eligible),
    .last_served (last_q),
    .pick        (pick),
    .found       (found)
  );

  assign out_valid = busy_q & ~buf_empty[gnt_q];
  assign out_data  = head_data[gnt_q];
  assign out_last  = head_last[gnt_q];
  assign xfer      = out_valid & out_ready;
  assign take      = ~busy_q & found;

  always_comb begin
    busy_d = busy_q;
    gnt_d  = gnt_q;
    last_d = last_q;
    if (take) begin
      busy_d = 1'b1;
      gnt_d  = pick;
      last_d = pick;
    end else if (xfer && out_last) begin
      busy_d = 1'b0;
    end
    gnt_en = take | (xfer & out_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      gnt_q  <= SRC_Y;
      last_q <= SRC_TERM;
    end else if (gnt_en) begin
      busy_q <= busy_d;
      gnt_q  <= gnt_d;
      last_q <= last_d;
    end
  end

  alloc_stall_timer #(.STALL_LIMIT(STALL_LIMIT)) u_stall (
    .clk     (clk),
    .rst_n   (rst_n),
    .pending (~&buf_empty),
    .moved   (xfer),
    .alarm   (deadlock)
  );
endmodule

// File: rtl/mesh_out_alloc_chk.sv
module mesh_out_alloc_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_last,
  input logic [DATA_W-1:0] out_data,
  input logic              deadlock,
  input logic              busy,
  input logic [1:0]        gnt
);
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_grant_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(out_valid && out_ready && out_last)) |=> (busy && $stable(gnt)));

  assert_sticky_alarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |=> deadlock);

  assert_alarm_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deadlock) |-> $past(!(out_valid && out_ready)));
endmodule

bind mesh_out_alloc mesh_out_alloc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_last  (out_last),
  .out_data  (out_data),
  .deadlock  (deadlock),
  .busy      (busy_q),
  .gnt       (gnt_q)
);

// File: tb/tb_mesh_out_alloc.sv
module tb_mesh_out_alloc;
  localparam int CLK_P = 10;
  localparam int DW    = 8;
  localparam int LIM   = 20;

  logic clk, rst_n, out_ready, log_clr;
  logic [3*DW-1:0] drv_data;
  logic [2:0] drv_last, drv_valid, gv, all_rdy;
  logic [2:0] rdy0, rdy1, rdy2;
  logic [2:0] o_valid, o_last, o_dead;
  logic [DW-1:0] o_data [3];

  int n_chk, n_bad;
  logic [8:0] logw [3][16];
  int logn [3];
  logic [8:0] exp_w [16];
  int exp_n;
  bit done_flag;

  assign all_rdy = rdy0 & rdy1 & rdy2;
  assign gv = drv_valid & all_rdy;

  mesh_out_alloc #(.DATA_W(DW), .BUF_LOG2(2), .STALL_LIMIT(LIM), .ROUND_ROBIN(1'b0), .CUT_THROUGH(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .in_data(drv_data), .in_last(drv_last), .in_valid(gv), .in_ready(rdy0),
    .out_data(o_data[0]), .out_last(o_last[0]), .out_valid(o_valid[0]), .out_ready(out_ready), .deadlock(o_dead[0]));
  mesh_out_alloc #(.DATA_W(DW), .BUF_LOG2(2), .STALL_LIMIT(LIM), .ROUND_ROBIN(1'b1), .CUT_THROUGH(1'b0)) dut_rr (
    .clk(clk), .rst_n(rst_n), .in_data(drv_data), .in_last(drv_last), .in_valid(gv), .in_ready(rdy1),
    .out_data(o_data[1]), .out_last(o_last[1]), .out_valid(o_valid[1]), .out_ready(out_ready), .deadlock(o_dead[1]));
  mesh_out_alloc #(.DATA_W(DW), .BUF_LOG2(2), .STALL_LIMIT(LIM), .ROUND_ROBIN(1'b0), .CUT_THROUGH(1'b1)) dut_ct (
    .clk(clk), .rst_n(rst_n), .in_data(drv_data), .in_last(drv_last), .in_valid(gv), .in_ready(rdy2),
    .out_data(o_data[2]), .out_last(o_last[2]), .out_valid(o_valid[2]), .out_ready(out_ready), .deadlock(o_dead[2]));

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    for (int d = 0; d < 3; d++) begin
      if (log_clr) logn[d] <= 0;
      else if (o_valid[d] && out_ready && logn[d] < 16) begin
        logw[d][logn[d]] <= {o_last[d], o_data[d]};
        logn[d] <= logn[d] + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; out_ready = 1'b0; drv_valid = '0; drv_last = '0; drv_data = '0;
    log_clr = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    #1 log_clr = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic set_word(input int lane, input logic [1:0] src, input logic [5:0] tag, input logic lst);
    drv_data[lane*DW +: DW] = {src, tag};
    drv_last[lane] = lst;
  endtask

  task automatic push(input logic [2:0] m);
    logic [2:0] pend, got;
    pend = m;
    drv_valid = pend;
    while (pend != 0) begin
      @(negedge clk);
      got = pend & all_rdy;
      @(posedge clk); #1;
      pend = pend & ~got;
      drv_valid = pend;
    end
  endtask

  task automatic check_log(input int d, input string req);
    check(logn[d] == exp_n, req, logn[d], exp_n);
    for (int k = 0; k < exp_n && k < logn[d]; k++)
      check(logw[d][k] == exp_w[k], req, logw[d][k], exp_w[k]);
  endtask

  function automatic logic [8:0] w9(input logic lst, input logic [1:0] src, input logic [5:0] tag);
    return {lst, src, tag};
  endfunction

  initial begin
    #(CLK_P*150000);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done_flag = 0;
    rst_n = 1'b0; out_ready = 1'b0; drv_valid = '0; drv_last = '0; drv_data = '0; log_clr = 1'b1;
    @(negedge clk);
    // R1 during reset
    check(o_valid == 3'b000, "R1 valid in reset", o_valid, 0);
    do_reset();
    @(negedge clk);
    check(o_valid == 3'b000, "R1 valid", o_valid, 0);
    check(rdy0 == 3'b111 && rdy1 == 3'b111 && rdy2 == 3'b111, "R1 ready", {rdy0, rdy1, rdy2}, 9'h1ff);
    check(o_dead == 3'b000, "R1 deadlock", o_dead, 0);
    @(posedge clk); #1;

    // R2 / R3 sweep over every set of competing lanes, one word each
    for (int m = 1; m < 8; m++) begin
      do_reset();
      for (int i = 0; i < 3; i++) set_word(i, 2'(i), 6'(m), 1'b1);
      push(3'(m));
      out_ready = 1'b1;
      cycles(12);
      exp_n = 0;
      for (int i = 0; i < 3; i++)
        if (m[i]) begin exp_w[exp_n] = w9(1'b1, 2'(i), 6'(m)); exp_n++; end
      check_log(0, "R2 fixed order sweep");
      check_log(1, "R3 rotation from reset sweep");
      check_log(2, "R6 complete packets fixed order");
    end

    // R2 / R3 two packets on lane 0 against one each on lanes 1 and 2
    do_reset();
    set_word(0, 2'd0, 6'd1, 1'b1); set_word(1, 2'd1, 6'd1, 1'b1); set_word(2, 2'd2, 6'd1, 1'b1);
    push(3'b111);
    set_word(0, 2'd0, 6'd2, 1'b1);
    push(3'b001);
    out_ready = 1'b1;
    cycles(14);
    exp_n = 4;
    exp_w[0] = w9(1, 0, 1); exp_w[1] = w9(1, 0, 2); exp_w[2] = w9(1, 1, 1); exp_w[3] = w9(1, 2, 1);
    check_log(0, "R2 Y before X before terminal");
    exp_w[1] = w9(1, 1, 1); exp_w[2] = w9(1, 2, 1); exp_w[3] = w9(1, 0, 2);
    check_log(1, "R3 served lane goes last");

    // R4 / R5 / R6 partial packet on X, then complete packet on Y
    do_reset();
    out_ready = 1'b1;
    set_word(1, 2'd1, 6'd0, 1'b0);
    push(3'b010);
    cycles(3);
    set_word(0, 2'd0, 6'd5, 1'b1);
    push(3'b001);
    cycles(3);
    set_word(1, 2'd1, 6'd1, 1'b1);
    push(3'b010);
    cycles(8);
    exp_n = 3;
    exp_w[0] = w9(0, 1, 0); exp_w[1] = w9(1, 1, 1); exp_w[2] = w9(1, 0, 5);
    check_log(0, "R4 R5 grant held through packet");
    check_log(1, "R4 grant held round robin");
    exp_w[0] = w9(1, 0, 5); exp_w[1] = w9(0, 1, 0); exp_w[2] = w9(1, 1, 1);
    check_log(2, "R6 partial packet waits");

    // R7 packet of six words through a four word buffer
    do_reset();
    out_ready = 1'b1;
    for (int k = 0; k < 6; k++) begin
      set_word(1, 2'd1, 6'(k), (k == 5));
      push(3'b010);
    end
    cycles(10);
    exp_n = 6;
    for (int k = 0; k < 6; k++) exp_w[k] = w9((k == 5), 2'd1, 6'(k));
    check_log(2, "R7 oversize cut-through fallback");
    check_log(0, "R7 oversize wormhole");

    // R8 backpressure hold
    do_reset();
    set_word(0, 2'd0, 6'd9, 1'b0);
    push(3'b001);
    set_word(0, 2'd0, 6'd10, 1'b1);
    push(3'b001);
    cycles(2);
    @(negedge clk);
    check(o_valid[0] && o_data[0] == 8'h09 && !o_last[0], "R8 held word", {o_valid[0], o_data[0]}, 9'h109);
    cycles(3);
    @(negedge clk);
    check(o_valid[0] && o_data[0] == 8'h09 && !o_last[0], "R8 still held", {o_valid[0], o_data[0]}, 9'h109);
    @(posedge clk); #1;

    // R11 buffer depth
    do_reset();
    for (int k = 0; k < 4; k++) begin set_word(0, 2'd0, 6'(k), 1'b1); push(3'b001); end
    @(negedge clk);
    check(rdy0 == 3'b110 && rdy1 == 3'b110 && rdy2 == 3'b110, "R11 full lane not ready", {rdy0, rdy1, rdy2}, 9'h1b6);
    @(posedge clk); #1;

    // R9 / R10 threshold and stickiness
    do_reset();
    set_word(0, 2'd0, 6'd3, 1'b1);
    push(3'b001);
    cycles(10);
    @(negedge clk);
    check(o_dead == 3'b000, "R9 short stall no alarm", o_dead, 0);
    cycles(20);
    @(negedge clk);
    check(o_dead == 3'b111, "R9 long stall alarm", o_dead, 7);
    @(posedge clk); #1;
    out_ready = 1'b1;
    cycles(6);
    @(negedge clk);
    check(o_dead == 3'b111, "R10 alarm sticky after drain", o_dead, 7);
    check(logn[0] == 1, "R10 word drained", logn[0], 1);
    @(posedge clk); #1;

    // R9 restart of the count on a transfer
    do_reset();
    for (int k = 0; k < 3; k++) begin set_word(0, 2'd0, 6'(k), 1'b1); push(3'b001); end
    cycles(12);
    out_ready = 1'b1;
    cycles(1);
    out_ready = 1'b0;
    cycles(15);
    @(negedge clk);
    check(o_dead == 3'b000, "R9 count restarted", o_dead, 0);
    check(logn[0] == 1, "R9 one word moved", logn[0], 1);
    cycles(10);
    @(negedge clk);
    check(o_dead == 3'b111, "R9 alarm after restart", o_dead, 7);

    done_flag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule